// File: doc/BRIEF.md
# Sleep Mode Controller

This block decides when a small 8-bit processor core goes to sleep, which clock domains are switched off while it sleeps, and how it comes back. Software programs a sleep-control register that holds an enable bit and a 3-bit mode code. The core then raises a one-cycle sleep strobe when it executes its sleep instruction. If the enable bit is set at that moment, the controller holds the CPU and turns off the clock enables that the selected mode calls for. If the bit is clear, the strobe is ignored.

While the core sleeps, the controller compares incoming interrupt requests against a wake mask that depends on the mode. An accepted interrupt starts a wake sequence. First there is an oscillator start-up wait, whose length depends on the mode. Then a fixed four-cycle CPU hold follows. After that the CPU is released and a one-cycle resume pulse tells it to take the interrupt and then continue after the sleep instruction. A reset request that arrives while the core is asleep or waking ends the sequence at once and gives a one-cycle reset-vector pulse instead of the resume pulse. An external level interrupt wakes the core only if it stays high for a programmable number of consecutive cycles.

The controller does not clear the register file or any memory on wake, so their contents survive sleep.

Top module: `slp_ctrl`

## Requirements
- R1: A sleep strobe enters sleep only when the enable bit in the sleep-control register is 1. With the bit at 0, the strobe has no effect: `cpu_hold_o` stays 0 and all clock enables stay 1. The register is loaded from `cfg_en_i` and `cfg_mode_i` on a clock edge where `cfg_we_i` is 1, and the strobe is judged against the value the register held before that edge.
- R2: The mode codes are 000 for Idle, 001 for Converter-quiet, 010 for Power-down and 100 for Standby; every other code acts as Idle. The bits of `clk_en_o` are [0] CPU, [1] NVM, [2] I/O, [3] timer, [4] analog and [5] watchdog. From the cycle after an accepted strobe, `cpu_hold_o` is 1 and `clk_en_o` is 6'b111100 in Idle, 6'b111000 in Converter-quiet, and 6'b100000 in Standby and Power-down.
- R3: Out of reset and whenever the CPU is not held, `clk_en_o` is 6'b111111 and `cpu_hold_o` is 0.
- R4: While asleep, the watchdog request and a qualified external level request always wake the core. In Idle, any bit of `int_irq_i` also wakes it. In Converter-quiet, only `int_irq_i[0]` does. In Standby and Power-down, `int_irq_i` is ignored and the core stays asleep with the same clock enables.
- R5: An accepted wake keeps `cpu_hold_o` at 1 for S+4 cycles, counted from the edge that samples the wake. S is 0 in Idle and Converter-quiet, STBY_START in Standby and PD_START in Power-down.
- R6: In the first cycle after the hold ends following an interrupt wake, `resume_o` is 1 for exactly one cycle.
- R7: If `wake_rst_i` is sampled while the CPU is held, the next cycle has `cpu_hold_o` at 0, all clocks enabled, `rst_vec_o` at 1 for one cycle, and no `resume_o` pulse.
- R8: `ext_lvl_irq_i` wakes the core only when it has been sampled high for LVL_HOLD consecutive sleeping cycles. A shorter pulse leaves the core asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Write strobe for the sleep-control register |
| cfg_en_i | input | 1 | Sleep enable bit value to write |
| cfg_mode_i | input | 3 | Mode code to write |
| sleep_strobe_i | input | 1 | One-cycle pulse when the CPU executes its sleep instruction |
| ext_lvl_irq_i | input | 1 | Enabled external level-triggered interrupt request |
| wdt_irq_i | input | 1 | Enabled watchdog interrupt request |
| int_irq_i | input | NINT | Other enabled internal interrupt requests |
| wake_rst_i | input | 1 | Reset request that redirects a wake to the reset vector |
| clk_en_o | output | 6 | Per-domain clock enables |
| cpu_hold_o | output | 1 | Holds the CPU while asleep or waking |
| resume_o | output | 1 | One-cycle pulse: service the interrupt, then continue after the sleep instruction |
| rst_vec_o | output | 1 | One-cycle pulse: start execution at the reset vector |

## Verification
Several rules are checked by assertions on every cycle:
- the clocks are fully on whenever the CPU is released;
- the CPU clock is never gated while the CPU runs;
- a strobe with the enable bit clear never raises the hold;
- a resume pulse always follows at least four held cycles;
- resume and reset-vector pulses are single-cycle and never coincide.

Other behaviour can only be shown by the bench's scenarios. This covers the exact hold length for each mode's start-up count, which interrupt sources each mode ignores, the level-pulse qualification length, and a reset request landing in the middle of the start-up wait.

// File: rtl/slp_pkg.sv
package slp_pkg;

  localparam int NDOM = 6;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_CQUIET = 2'd1,
    MD_STBY  = 2'd2,
    MD_PDOWN = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_START = 2'd2,
    ST_HOLD  = 2'd3
  } state_e;

  // Software mode code to internal mode; unlisted codes fall back to Idle.
  function automatic mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'b001:  decode_mode = MD_CQUIET;
      3'b010:  decode_mode = MD_PDOWN;
      3'b100:  decode_mode = MD_STBY;
      default: decode_mode = MD_IDLE;
    endcase
  endfunction

  // Clock enables while asleep: [0] cpu [1] nvm [2] io [3] timer [4] analog [5] watchdog
  function automatic logic [NDOM-1:0] gate_of(input mode_e m);
    case (m)
      MD_IDLE:   gate_of = 6'b111100;
      MD_CQUIET: gate_of = 6'b111000;
      default:   gate_of = 6'b100000;
    endcase
  endfunction

endpackage

// File: rtl/slp_ctl_reg.sv
module slp_ctl_reg
  import slp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  logic       en_d_i,
  input  logic [2:0] code_d_i,
  output logic       en_o,
  output mode_e      mode_o
);

  logic       en_q;
  logic [2:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= 3'b000;
    end else if (we_i) begin
      en_q   <= en_d_i;
      code_q <= code_d_i;
    end
  end

  assign en_o   = en_q;
  assign mode_o = decode_mode(code_q);

endmodule

// File: rtl/slp_lvl_filter.sv
module slp_lvl_filter #(
  parameter int LVL_HOLD = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic lvl_i,
  output logic ok_o
);

  localparam int CW = (LVL_HOLD > 2) ? $clog2(LVL_HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(LVL_HOLD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (arm_i && lvl_i) begin
      cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ok_o = arm_i && lvl_i && (cnt_q == LAST);

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int NINT       = 3,
  parameter int STBY_START = 6,
  parameter int PD_START   = 10,
  parameter int HOLD_CYC   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_i,
  input  logic            en_i,
  input  mode_e           mode_cfg_i,
  input  logic            ext_ok_i,
  input  logic            wdt_i,
  input  logic [NINT-1:0] int_i,
  input  logic            wake_rst_i,
  output logic            asleep_o,
  output logic [NDOM-1:0] clk_en_o,
  output logic            hold_o,
  output logic            resume_o,
  output logic            rst_vec_o
);

  localparam int MAXS = (PD_START > STBY_START) ? PD_START : STBY_START;
  localparam int MAXC = (MAXS > HOLD_CYC) ? MAXS : HOLD_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);

  state_e        st_q, st_d;
  mode_e         mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          res_q, res_d, rstv_q, rstv_d;
  logic          wake;
  logic [CW-1:0] slen;

  always_comb begin
    case (mode_q)
      MD_IDLE:   wake = ext_ok_i | wdt_i | (|int_i);
      MD_CQUIET: wake = ext_ok_i | wdt_i | int_i[0];
      default:   wake = ext_ok_i | wdt_i;
    endcase
    case (mode_q)
      MD_STBY:  slen = CW'(STBY_START);
      MD_PDOWN: slen = CW'(PD_START);
      default:  slen = '0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    mode_d = mode_q;
    cnt_d  = cnt_q;
    res_d  = 1'b0;
    rstv_d = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (strobe_i && en_i) begin
          st_d   = ST_SLEEP;
          mode_d = mode_cfg_i;
        end
      end
      ST_SLEEP: begin
        if (wake_rst_i) begin
          st_d   = ST_RUN;
          rstv_d = 1'b1;
        end else if (wake) begin
          if (slen != '0) begin
            st_d  = ST_START;
            cnt_d = slen - 1'b1;
          end else begin
            st_d  = ST_HOLD;
            cnt_d = HOLD_LAST;
          end
        end
      end
      ST_START: begin
        if (wake_rst_i) begin
          st_d   = ST_RUN;
          rstv_d = 1'b1;
        end else if (cnt_q == '0) begin
          st_d  = ST_HOLD;
          cnt_d = HOLD_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (wake_rst_i) begin
          st_d   = ST_RUN;
          rstv_d = 1'b1;
        end else if (cnt_q == '0) begin
          st_d  = ST_RUN;
          res_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      mode_q <= MD_IDLE;
      cnt_q  <= '0;
      res_q  <= 1'b0;
      rstv_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      res_q  <= res_d;
      rstv_q <= rstv_d;
    end
  end

  assign asleep_o  = (st_q == ST_SLEEP);
  assign hold_o    = (st_q != ST_RUN);
  assign clk_en_o  = (st_q == ST_SLEEP || st_q == ST_START) ? gate_of(mode_q) : '1;
  assign resume_o  = res_q;
  assign rst_vec_o = rstv_q;

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int NINT       = 3,
  parameter int STBY_START = 6,
  parameter int PD_START   = 10,
  parameter int HOLD_CYC   = 4,
  parameter int LVL_HOLD   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we_i,
  input  logic            cfg_en_i,
  input  logic [2:0]      cfg_mode_i,
  input  logic            sleep_strobe_i,
  input  logic            ext_lvl_irq_i,
  input  logic            wdt_irq_i,
  input  logic [NINT-1:0] int_irq_i,
  input  logic            wake_rst_i,
  output logic [5:0]      clk_en_o,
  output logic            cpu_hold_o,
  output logic            resume_o,
  output logic            rst_vec_o
);

  logic [1:0] rst_sync_q;
  logic       rst_ni;
  logic       ctl_en;
  mode_e      ctl_mode;
  logic       asleep;
  logic       ext_ok;

  // Asserts asynchronously, releases on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  slp_ctl_reg i_reg (
    .clk      (clk),
    .rst_n    (rst_ni),
    .we_i     (cfg_we_i),
    .en_d_i   (cfg_en_i),
    .code_d_i (cfg_mode_i),
    .en_o     (ctl_en),
    .mode_o   (ctl_mode)
  );

  slp_lvl_filter #(.LVL_HOLD(LVL_HOLD)) i_lvl (
    .clk   (clk),
    .rst_n (rst_ni),
    .arm_i (asleep),
    .lvl_i (ext_lvl_irq_i),
    .ok_o  (ext_ok)
  );

  slp_fsm #(
    .NINT       (NINT),
    .STBY_START (STBY_START),
    .PD_START   (PD_START),
    .HOLD_CYC   (HOLD_CYC)
  ) i_fsm (
    .clk        (clk),
    .rst_n      (rst_ni),
    .strobe_i   (sleep_strobe_i),
    .en_i       (ctl_en),
    .mode_cfg_i (ctl_mode),
    .ext_ok_i   (ext_ok),
    .wdt_i      (wdt_irq_i),
    .int_i      (int_irq_i),
    .wake_rst_i (wake_rst_i),
    .asleep_o   (asleep),
    .clk_en_o   (clk_en_o),
    .hold_o     (cpu_hold_o),
    .resume_o   (resume_o),
    .rst_vec_o  (rst_vec_o)
  );

endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_strobe_i,
  input logic       wake_rst_i,
  input logic       ctl_en,
  input logic [5:0] clk_en_o,
  input logic       cpu_hold_o,
  input logic       resume_o,
  input logic       rst_vec_o
);

  p_noop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hold_o && sleep_strobe_i && !ctl_en) |=> !cpu_hold_o);

  p_cpu_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_o[0] |-> cpu_hold_o);

  p_run_clocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hold_o |-> (clk_en_o == 6'b111111));

  p_hold_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> ($past(cpu_hold_o, 1) && $past(cpu_hold_o, 4)));

  p_resume_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> !resume_o);

  p_rst_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_vec_o |-> ($past(wake_rst_i) && !cpu_hold_o && !resume_o));

endmodule

bind slp_ctrl slp_ctrl_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sleep_strobe_i (sleep_strobe_i),
  .wake_rst_i     (wake_rst_i),
  .ctl_en         (ctl_en),
  .clk_en_o       (clk_en_o),
  .cpu_hold_o     (cpu_hold_o),
  .resume_o       (resume_o),
  .rst_vec_o      (rst_vec_o)
);

// File: tb/test_slp_ctrl.sv
`timescale 1ns/100ps
module test_slp_ctrl;

  localparam int NINT = 3;
  localparam int STBY = 6;
  localparam int PD   = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we, cfg_en, strobe, ext, wdt, wrst;
  logic [2:0]      cfg_mode;
  logic [NINT-1:0] intr;
  logic [5:0]      clk_en;
  logic            hold, resume, rvec;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  slp_ctrl #(.NINT(NINT), .STBY_START(STBY), .PD_START(PD), .HOLD_CYC(4), .LVL_HOLD(3)) i_slp_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en), .cfg_mode_i(cfg_mode),
    .sleep_strobe_i(strobe), .ext_lvl_irq_i(ext), .wdt_irq_i(wdt), .int_irq_i(intr),
    .wake_rst_i(wrst), .clk_en_o(clk_en), .cpu_hold_o(hold), .resume_o(resume), .rst_vec_o(rvec)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic       ext;
    logic       wdt;
    logic [2:0] intr;
    logic       wake;
    logic [5:0] gate;
    logic [7:0] lat;
  } vec_t;

  // lat: held cycles counted from the first driven cycle (ext needs 2 extra qualifying cycles)
  localparam vec_t VEC [12] = '{
    '{3'b000, 1'b0, 1'b0, 3'b010, 1'b1, 6'b111100, 8'd4},
    '{3'b000, 1'b0, 1'b1, 3'b000, 1'b1, 6'b111100, 8'd4},
    '{3'b000, 1'b1, 1'b0, 3'b000, 1'b1, 6'b111100, 8'd6},
    '{3'b001, 1'b0, 1'b0, 3'b001, 1'b1, 6'b111000, 8'd4},
    '{3'b001, 1'b0, 1'b0, 3'b100, 1'b0, 6'b111000, 8'd0},
    '{3'b010, 1'b0, 1'b1, 3'b000, 1'b1, 6'b100000, 8'd14},
    '{3'b010, 1'b0, 1'b0, 3'b010, 1'b0, 6'b100000, 8'd0},
    '{3'b010, 1'b1, 1'b0, 3'b000, 1'b1, 6'b100000, 8'd16},
    '{3'b100, 1'b0, 1'b1, 3'b000, 1'b1, 6'b100000, 8'd10},
    '{3'b100, 1'b0, 1'b0, 3'b001, 1'b0, 6'b100000, 8'd0},
    '{3'b011, 1'b0, 1'b0, 3'b100, 1'b1, 6'b111100, 8'd4},
    '{3'b101, 1'b0, 1'b0, 3'b001, 1'b1, 6'b111100, 8'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic en, input logic [2:0] m);
    @(negedge clk); cfg_we = 1'b1; cfg_en = en; cfg_mode = m;
    @(posedge clk); @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic do_strobe();
    @(negedge clk); strobe = 1'b1;
    @(posedge clk); @(negedge clk); strobe = 1'b0;
  endtask

  // Drives the sources at the current negedge, counts held cycles until release.
  task automatic wait_wake(input logic e, input logic w, input logic [2:0] iv,
                           output int n, output bit done);
    ext = e; wdt = w; intr = iv;
    n = 0; done = 1'b0;
    for (int k = 0; k < 40 && !done; k++) begin
      @(posedge clk); @(negedge clk);
      wdt = 1'b0; intr = '0;
      if (hold) n++; else done = 1'b1;
    end
    ext = 1'b0;
  endtask

  task automatic rst_wake(input string tag);
    wrst = 1'b1;
    @(posedge clk); @(negedge clk); wrst = 1'b0;
    chk({tag, " R7 rst_vec"}, rvec, 1'b1);
    chk({tag, " R7 hold"}, hold, 1'b0);
    chk({tag, " R7 no resume"}, resume, 1'b0);
    chk({tag, " R7 clocks"}, clk_en, 6'b111111);
    @(posedge clk); @(negedge clk);
    chk({tag, " R7 pulse ends"}, rvec, 1'b0);
    chk({tag, " R7 still no resume"}, resume, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int  n;
    bit  done;
    rst_n = 1'b0; cfg_we = 0; cfg_en = 0; cfg_mode = 0; strobe = 0;
    ext = 0; wdt = 0; intr = '0; wrst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R3 reset clocks", clk_en, 6'b111111);
    chk("R3 reset hold", hold, 1'b0);
    chk("R6 reset resume", resume, 1'b0);
    chk("R7 reset rst_vec", rvec, 1'b0);

    // R1: strobe with enable clear is a no-op
    cfg_write(1'b0, 3'b010);
    do_strobe();
    chk("R1 noop hold", hold, 1'b0);
    chk("R1 noop clocks", clk_en, 6'b111111);

    // Table walk: R2 gating, R4 masks, R5 latency, R6 resume, R7 exit
    foreach (VEC[i]) begin
      cfg_write(1'b1, VEC[i].mode);
      do_strobe();
      chk($sformatf("vec%0d R2 hold", i), hold, 1'b1);
      chk($sformatf("vec%0d R2 gate", i), clk_en, VEC[i].gate);
      wait_wake(VEC[i].ext, VEC[i].wdt, VEC[i].intr, n, done);
      if (VEC[i].wake) begin
        chk($sformatf("vec%0d R4 woke", i), done, 1'b1);
        chk($sformatf("vec%0d R5 hold cycles", i), n, VEC[i].lat);
        chk($sformatf("vec%0d R6 resume", i), resume, 1'b1);
        chk($sformatf("vec%0d R3 clocks", i), clk_en, 6'b111111);
        @(posedge clk); @(negedge clk);
        chk($sformatf("vec%0d R6 one cycle", i), resume, 1'b0);
      end else begin
        chk($sformatf("vec%0d R4 ignored", i), done, 1'b0);
        chk($sformatf("vec%0d R4 gate kept", i), clk_en, VEC[i].gate);
        rst_wake($sformatf("vec%0d", i));
      end
    end

    // R8: a two-cycle level pulse must not wake Idle; a three-cycle one must
    cfg_write(1'b1, 3'b000);
    do_strobe();
    ext = 1'b1;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    ext = 1'b0;
    repeat (5) begin @(posedge clk); @(negedge clk); end
    chk("R8 short pulse hold", hold, 1'b1);
    chk("R8 short pulse gate", clk_en, 6'b111100);
    wait_wake(1'b1, 1'b0, 3'b000, n, done);
    chk("R8 long pulse wakes", n, 6);
    chk("R6 after level wake", resume, 1'b1);

    // R7: reset request in the middle of the Power-down start-up wait
    cfg_write(1'b1, 3'b010);
    do_strobe();
    wdt = 1'b1;
    @(posedge clk); @(negedge clk); wdt = 1'b0;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    chk("R5 still starting", hold, 1'b1);
    chk("R2 gate during start", clk_en, 6'b100000);
    rst_wake("startup");
    repeat (15) begin @(posedge clk); @(negedge clk); end
    chk("R7 no late resume", resume, 1'b0);
    chk("R3 running after reset wake", hold, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule